// File: doc/BRIEF.md
# Programmable Serial Test Pattern Generator

This block drives a serial test stream for bit-error-rate measurement, one bit on each transmit clock edge. A single shift register of up to 32 stages serves two modes. In pseudorandom mode, two taps feed the register back: one is fixed at the last active stage and the other is programmable. In repetitive mode the same register rotates a user word of 1 to 32 bits.

A rising edge on the load input re-seeds the register. A low transmit-enable input turns an edge into a gap, so the stream can follow a clock with gaps in it. Errors can be forced into the stream in two ways: one flip on command, or one flip every 10^c bits. The error only corrupts the output bit, never the generator state. An inversion control complements the output.

Top module: `tpg_top`

## Requirements
- R1: While reset is asserted and after it is released, the internal output bit is 0, so `dout` equals `invert` until the first advancing edge.
- R2: A rising edge of `load` at clock edge E0 loads the register from `pattern` and holds `dout`. The first pattern bit appears on `dout` at the next edge E1 with `tx_en` high. Load also clears any pending single error and restarts the periodic interval.
- R3: Repetitive mode (`prbs_mode`=0), with N = `len_m1`+1. The output repeats `pattern[N-1]`, `pattern[N-2]`, ..., `pattern[0]`, with period N. Bits of `pattern` at positions N and above are ignored.
- R4: Pseudorandom mode (`prbs_mode`=1). Each advance shifts the N-bit state s left. The new bit entering stage 0 is s[N-1] XOR s[`tap_sel`]. The output bit is s[N-1] taken before the shift. A maximal tap choice gives period 2^N-1.
- R5: In pseudorandom mode, a seed whose lower N bits are all zero is replaced by N ones at load.
- R6: An edge with `tx_en` low and no load rising edge is a gap. The output, the generator state and the error-interval count all hold.
- R7: `invert` complements `dout` at once, without waiting for a clock edge.
- R8: A high `err_single` at an edge flips exactly one output bit: the one produced at the first later advancing edge. Later bits follow the uncorrupted pattern.
- R9: A `rate_code` c from 1 to 7 flips the k-th output bit after load (k counted from 0, gaps not counted) whenever (k+1) is a multiple of 10^c. Code 0 inserts no periodic errors.
- R10: When a single error and a periodic error fall on the same bit, that bit is flipped once.
- R11: Holding `load` high does not reload again. Only its rising edge acts, and the pattern keeps advancing while it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Low marks the edge as a gap |
| load | input | 1 | Rising edge reloads the generator |
| invert | input | 1 | Complement output data |
| prbs_mode | input | 1 | 1 pseudorandom, 0 repetitive |
| len_m1 | input | LEN_W | Pattern length minus one |
| tap_sel | input | LEN_W | Programmable feedback stage |
| pattern | input | PAT_W | Seed or repeated word |
| rate_code | input | 3 | Periodic error rate code |
| err_single | input | 1 | Request one inserted error |
| dout | output | 1 | Serial test data |

## Verification
The hardest case is an error request that arrives during a gap, followed by a chain of gaps, so that the flip has to land on a bit several clocks later. Another hard case is a single error that coincides with a periodic error. The bench sweeps runs with a gap on every third, fourth or fifth edge and places the single pulse at a chosen step. It also lines a pulse up with the tenth bit at rate code 1. For each bit, a bench model tracks the pattern index, the pending request and the interval, using only the stated rules.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned CNT_W  = 24;

  // N ones in the low bits of a 64-bit word
  function automatic logic [63:0] low_ones(input int unsigned n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // Bit interval for a rate code: 0 -> none, c -> 10^c
  function automatic logic [CNT_W-1:0] decade_len(input logic [RATE_W-1:0] code);
    logic [CNT_W-1:0] v;
    v = '0;
    if (code != '0) begin
      v = CNT_W'(1);
      for (int i = 0; i < (1 << RATE_W) - 1; i++)
        if (i < int'(code)) v = v * CNT_W'(10);
    end
    return v;
  endfunction
endpackage

// File: rtl/tpg_shift.sv
module tpg_shift #(
  parameter int unsigned PAT_W = 32,
  parameter int unsigned LEN_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             prbs_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic [LEN_W-1:0] tap_i,
  input  logic [PAT_W-1:0] seed_i,
  output logic             head_o
);
  logic [63:0]      mask_wide;
  logic [PAT_W-1:0] mask;
  logic [PAT_W-1:0] seed_m;
  logic [PAT_W-1:0] seed_fix;
  logic [PAT_W-1:0] sr_q;
  logic [PAT_W-1:0] sr_next;
  logic             head;
  logic             fb;

  assign mask_wide = tpg_pkg::low_ones(32'(len_m1_i) + 32'd1);
  assign mask      = mask_wide[PAT_W-1:0];
  assign seed_m    = seed_i & mask;
  assign seed_fix  = (prbs_i && seed_m == '0) ? mask : seed_m;
  assign head      = sr_q[len_m1_i];
  assign fb        = head ^ (prbs_i & sr_q[tap_i]);
  assign sr_next   = ((sr_q << 1) | {{(PAT_W-1){1'b0}}, fb}) & mask;
  assign head_o    = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (load_i) sr_q <= seed_fix;
    else if (adv_i)  sr_q <= sr_next;
  end

  // R5
  nonzero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && prbs_i) |=> (sr_q != '0));

  // R3
  rotate_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !prbs_i) |=>
      ($countones(sr_q & $past(mask)) == $past($countones(sr_q & mask))));

  // R3
  load_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ((sr_q & ~$past(mask)) == '0));
endmodule

// File: rtl/tpg_errins.sv
module tpg_errins #(
  parameter int unsigned RATE_W = tpg_pkg::RATE_W,
  parameter int unsigned CNT_W  = tpg_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              single_i,
  output logic              flip_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  lim;
  logic [CNT_W-1:0]  cnt_q;
  logic [RATE_W-1:0] rate_q;
  logic              pend_q;
  logic              rate_same;
  logic              per_hit;
  logic              single_hit;

  assign lim        = tpg_pkg::decade_len(rate_i);
  assign rate_same  = (rate_i == rate_q);
  assign per_hit    = adv_i && rate_same && (rate_i != '0) && (cnt_q == lim - ONE);
  assign single_hit = adv_i && pend_q;
  assign flip_o     = per_hit | single_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
      pend_q <= 1'b0;
    end else begin
      rate_q <= rate_i;
      if (load_i || !rate_same)         cnt_q <= '0;
      else if (adv_i && rate_i != '0)   cnt_q <= per_hit ? '0 : cnt_q + ONE;
      pend_q <= load_i ? 1'b0 : ((pend_q & ~adv_i) | single_i);
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_same && rate_i != '0) |-> (cnt_q < lim));

  // R8
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && adv_i && !single_i && !load_i) |=> !pend_q);

  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0 && !pend_q));
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int unsigned PAT_W = 32,
  parameter int unsigned LEN_W = $clog2(PAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              load,
  input  logic              invert,
  input  logic              prbs_mode,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [LEN_W-1:0]  tap_sel,
  input  logic [PAT_W-1:0]  pattern,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              err_single,
  output logic              dout
);
  logic load_q;
  logic load_rise;
  logic adv;
  logic head;
  logic flip;
  logic raw_q;

  assign load_rise = load & ~load_q;
  assign adv       = tx_en & ~load_rise;

  tpg_shift #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load_rise), .adv_i(adv),
    .prbs_i(prbs_mode), .len_m1_i(len_m1), .tap_i(tap_sel),
    .seed_i(pattern), .head_o(head)
  );

  tpg_errins #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .load_i(load_rise), .adv_i(adv),
    .rate_i(rate_code), .single_i(err_single), .flip_o(flip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      load_q <= load;
      if (adv) raw_q <= head ^ flip;
    end
  end

  assign dout = raw_q ^ invert;

  // R6
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> $stable(raw_q));

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> $stable(raw_q));

  // R11
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && $past(load) && $past(rst_n)) |-> !load_rise);

  // R10
  flip_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip |-> adv);
endmodule

// File: tb/tb_tpg_top.sv
module tb_tpg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        load = 1'b0;
  logic        invert = 1'b0;
  logic        prbs_mode = 1'b0;
  logic [4:0]  len_m1 = '0;
  logic [4:0]  tap_sel = '0;
  logic [31:0] pattern = '0;
  logic [2:0]  rate_code = '0;
  logic        err_single = 1'b0;
  logic        dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic rec [0:511];

  always #4 clk = ~clk;

  tpg_top dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .load(load), .invert(invert),
    .prbs_mode(prbs_mode), .len_m1(len_m1), .tap_sel(tap_sel),
    .pattern(pattern), .rate_code(rate_code), .err_single(err_single),
    .dout(dout)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] bstep(input logic [31:0] s, input int n, input int tap);
    logic b;
    b = s[n-1] ^ s[tap];
    return ((s << 1) | {31'd0, b}) & nmask(n);
  endfunction

  function automatic int pow10(input int c);
    int v = 1;
    for (int i = 0; i < c; i++) v = v * 10;
    return (c == 0) ? 0 : v;
  endfunction

  task automatic run(input string tag, input bit prbs, input int n, input int tap,
                     input logic [31:0] seed, input int rate, input bit inv,
                     input int nbits, input int gap_every, input int single_at,
                     input bit keep_load);
    int k = -1;
    int step = 0;
    int m;
    logic [31:0] st;
    logic exp_raw = 1'b0;
    logic pbit, d0;
    bit pend = 1'b0;
    bit en, per, sg;
    string tg;
    m  = pow10(rate);
    st = seed & nmask(n);
    if (prbs && st == '0) st = nmask(n);
    @(negedge clk);
    tx_en = 1'b1; err_single = 1'b0; invert = inv; prbs_mode = prbs;
    len_m1 = 5'(n-1); tap_sel = 5'(tap); pattern = seed; rate_code = 3'(rate);
    load = 1'b1;
    #1 d0 = dout;
    @(negedge clk);
    chk("R2", dout, d0); // load edge holds the output
    load = keep_load;
    while (k < nbits-1 && step < 10*nbits+20) begin
      en = (gap_every == 0) || ((step % gap_every) != gap_every-1);
      tx_en = en;
      err_single = (step == single_at);
      @(negedge clk);
      if (en) begin
        k++;
        pbit = prbs ? st[n-1] : seed[n-1-(k%n)];
        if (prbs) st = bstep(st, n, tap);
        per = (m != 0) && (((k+1) % m) == 0);
        sg = pend;
        pend = 1'b0;
        exp_raw = pbit ^ (per | sg);
        tg = (per && sg) ? "R10" : sg ? "R8" : per ? "R9" : (k == 0) ? "R2" : tag;
        if (k < 512) rec[k] = dout ^ inv;
      end else begin
        tg = "R6";
      end
      if (step == single_at) pend = 1'b1;
      if (k >= 0) chk(tg, dout, exp_raw ^ inv);
      step++;
    end
    err_single = 1'b0; tx_en = 1'b1; load = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ones;
    logic v;
    repeat (3) @(negedge clk);
    chk("R1", dout, 1'b0);
    invert = 1'b1;
    #1 chk("R1", dout, 1'b1);
    invert = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk("R1", dout, 1'b0);

    // R3 repetitive: upper pattern bits ignored, length 1 and full length
    run("R3", 1'b0, 8, 0, 32'hFFFF_FFB2, 0, 1'b0, 40, 0, -1, 1'b0);
    run("R3", 1'b0, 1, 0, 32'hFFFF_FFFE, 0, 1'b0, 10, 0, -1, 1'b0);
    run("R3", 1'b0, 32, 0, 32'hA5C3_0F1E, 0, 1'b0, 70, 0, -1, 1'b0);

    // R4 pseudorandom, period of a maximal 7-stage generator
    run("R4", 1'b1, 7, 5, 32'h0000_005A, 0, 1'b0, 260, 0, -1, 1'b0);
    ones = 0;
    for (int i = 0; i < 127; i++) begin
      chk_int("R4", int'(rec[i]), int'(rec[i+127]));
      ones += int'(rec[i]);
    end
    chk_int("R4", ones, 64);
    run("R4", 1'b1, 15, 13, 32'h0000_0001, 0, 1'b0, 100, 0, -1, 1'b0);

    // R5 zero seed replaced
    run("R5", 1'b1, 7, 5, 32'hFFFF_FF00, 0, 1'b0, 30, 0, -1, 1'b0);

    // R6 gap clocking
    run("R6", 1'b1, 9, 4, 32'h0000_0123, 0, 1'b0, 60, 4, -1, 1'b0);

    // R7 inversion, registered stream and immediate toggle
    run("R7", 1'b0, 5, 0, 32'h0000_0013, 0, 1'b1, 20, 0, -1, 1'b0);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    v = dout;
    invert = ~invert;
    #1 chk("R7", dout, ~v);
    invert = ~invert;
    #1 chk("R7", dout, v);
    tx_en = 1'b1;

    // R8 single error requested inside a gap pattern
    run("R8", 1'b1, 7, 5, 32'h0000_0011, 0, 1'b0, 50, 3, 20, 1'b0);
    run("R8", 1'b0, 6, 0, 32'h0000_002D, 0, 1'b0, 30, 0, 7, 1'b0);

    // R9 periodic insertion at several rates
    run("R9", 1'b1, 9, 4, 32'h0000_0077, 1, 1'b0, 45, 5, -1, 1'b0);
    run("R9", 1'b0, 4, 0, 32'h0000_0009, 2, 1'b0, 250, 0, -1, 1'b0);
    run("R9", 1'b1, 15, 13, 32'h0000_4321, 3, 1'b0, 2050, 0, -1, 1'b0);

    // R10 coincident single and periodic error
    run("R10", 1'b1, 7, 5, 32'h0000_0033, 1, 1'b0, 25, 0, 8, 1'b0);

    // R11 load held high
    run("R11", 1'b0, 6, 0, 32'h0000_0035, 0, 1'b0, 20, 0, -1, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule